// File: doc/BRIEF.md
# Debug Mode Entry Arbiter

The arbiter decides, once per clock, whether a processor accepts a pending request to change execution mode. Requests arrive from a set of prioritised interrupt levels, from the exception logic and from the debug logic. Each requesting class owns one mask bit. A request whose bit is set is held off. When a request is accepted, the arbiter moves to the matching mode and sets the mask bits of that class and of every class below it, so that only more urgent work can pre-empt it. Privileged software can overwrite the whole mask through a write port. This lets it re-open lower classes, or re-open debug entry while it runs a monitor.

Debug entry has two targets. With the monitor select input high, a debug request from ordinary code enters monitor mode, where a software monitor runs with every class masked. With the select low, the request enters a halted on-chip-debug mode instead. A debug request accepted while the monitor is running always goes to the halted mode, whatever the select input says, so the monitor itself can be debugged. Both debug modes keep the mode and mask that were current when they were entered. A return strobe puts that context back on the outputs in the same cycle. Register saving is represented only by a one-cycle save pulse after every accepted entry.

Top module: `dbg_entry_arb`

## Requirements
- R1: A request whose mask bit is set is never taken. Mask bit i (for i below NUM_LVL) belongs to interrupt level i, bit NUM_LVL belongs to the exception request and bit NUM_LVL+1 belongs to the debug request.
- R2: Among the unmasked requests the one with the highest priority is taken: debug first, then exception, then interrupt levels from highest index to lowest. At most one request is taken per cycle, and `mode_o` shows the new mode from the next clock edge.
- R3: Taking interrupt level i or the exception request (class index c = i or NUM_LVL) sets mask bits 0 through c and keeps every higher bit as it was. The mode becomes c+1: code 0 is the base user/supervisor mode, codes 1..NUM_LVL are interrupt levels 0..NUM_LVL-1, and NUM_LVL+1 is exception.
- R4: Taking a debug request sets every mask bit. From any mode other than monitor, it enters monitor mode (code NUM_LVL+2) when `mon_sel_i` is 1 and the halted mode (code NUM_LVL+3) when it is 0.
- R5: A debug request taken while in monitor mode, after software has cleared the debug mask bit, enters the halted mode even when `mon_sel_i` is 1.
- R6: `dbg_status_o` is 1 exactly when the shown mode is the halted mode. `sr_dbg_o` is 1 exactly when it is monitor or halted.
- R7: While in the halted mode no request of any class is taken.
- R8: A mask write replaces the whole mask from the next edge. In the cycle of a write, no request is taken.
- R9: `ret_i` in monitor or halted mode restores the mode and mask held at entry to that mode. The restored values appear on `mode_o` and `mask_o` in the same cycle as `ret_i` and are held from the next edge. The return beats a mask write in the same cycle. In any other mode `ret_i` has no effect.
- R10: `save_o` is 1 for exactly the one cycle after each accepted entry and 0 otherwise.
- R11: After reset the mode is 0, the mask is all zero and `dbg_status_o`, `sr_dbg_o` and `save_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_i | input | NUM_LVL | Interrupt level requests, higher index is more urgent |
| exc_i | input | 1 | Exception request |
| dbg_i | input | 1 | Debug request |
| mon_sel_i | input | 1 | 1 selects monitor-style debug entry, 0 selects halted entry |
| ret_i | input | 1 | Return-from-debug strobe |
| msk_we_i | input | 1 | Privileged mask write enable |
| msk_wdata_i | input | NUM_LVL+2 | Mask value to write |
| mode_o | output | clog2(NUM_LVL+4) | Current execution mode code |
| mask_o | output | NUM_LVL+2 | Current per-class mask bits |
| dbg_status_o | output | 1 | Halted debug mode flag |
| sr_dbg_o | output | 1 | Status-register debug flag (monitor or halted) |
| save_o | output | 1 | One-cycle context save pulse after an entry |

## Verification
The hardest state to reach is a nested debug stack. The block must be in monitor mode with the debug mask re-opened by a write, then take a debug request into the halted mode, then unwind through two returns that must each restore a different saved context. The directed part of the bench walks to that state on purpose. It climbs through two interrupt levels and the exception, enters monitor, writes a mask with the debug bit clear, raises debug with the monitor select still high, then returns twice and once more from exception mode, where the return must do nothing. After that a long random phase with frequent mask writes reopens classes at random. Every cycle is compared against a behavioural model.

// File: rtl/dea_pkg.sv
package dea_pkg;

   // per-cycle decision of the arbiter, in order of precedence
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_RET   = 2'd1,
      ACT_WRITE = 2'd2,
      ACT_ENTER = 2'd3
   } dea_act_e;

endpackage

// File: rtl/dea_prio_pick.sv
module dea_prio_pick #(
   parameter  int N = 6,
   localparam int W = $clog2(N)
) (
   input  logic [N-1:0] req_i,
   output logic         vld_o,
   output logic [W-1:0] idx_o
);

   if (N < 2) begin : g_bad_n
      $error("dea_prio_pick: N must be at least 2");
   end

   // highest set index wins
   always_comb begin
      vld_o = |req_i;
      idx_o = '0;
      for (int k = 0; k < N; k++) begin
         if (req_i[k]) idx_o = W'(k);
      end
   end

endmodule

// File: rtl/dea_mask_fill.sv
module dea_mask_fill #(
   parameter  int N = 6,
   localparam int W = $clog2(N)
) (
   input  logic [W-1:0] idx_i,
   output logic [N-1:0] fill_o
);

   // thermometer: bits 0..idx set
   for (genvar j = 0; j < N; j++) begin : g_bit
      assign fill_o[j] = (idx_i >= W'(j));
   end

endmodule

// File: rtl/dea_ctx_slot.sv
module dea_ctx_slot #(
   parameter int MODE_W = 3,
   parameter int MSK_W  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_i,
   input  logic [MODE_W-1:0] mode_i,
   input  logic [MSK_W-1:0]  mask_i,
   output logic [MODE_W-1:0] mode_o,
   output logic [MSK_W-1:0]  mask_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_o <= '0;
         mask_o <= '0;
      end else if (ld_i) begin
         mode_o <= mode_i;
         mask_o <= mask_i;
      end
   end

endmodule

// File: rtl/dbg_entry_arb.sv
module dbg_entry_arb
   import dea_pkg::*;
#(
   parameter  int NUM_LVL = 4,
   localparam int CLS_N   = NUM_LVL + 2,
   localparam int CLS_W   = $clog2(CLS_N),
   localparam int MODE_W  = $clog2(NUM_LVL + 4)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_LVL-1:0] irq_i,
   input  logic              exc_i,
   input  logic              dbg_i,
   input  logic              mon_sel_i,
   input  logic              ret_i,
   input  logic              msk_we_i,
   input  logic [CLS_N-1:0]  msk_wdata_i,
   output logic [MODE_W-1:0] mode_o,
   output logic [CLS_N-1:0]  mask_o,
   output logic              dbg_status_o,
   output logic              sr_dbg_o,
   output logic              save_o
);

   if (NUM_LVL < 1 || NUM_LVL > 12) begin : g_bad_lvl
      $error("dbg_entry_arb: NUM_LVL must lie in 1..12");
   end

   localparam int DBG_BIT = NUM_LVL + 1;
   localparam logic [CLS_W-1:0]  DBG_IDX = CLS_W'(DBG_BIT);
   localparam logic [MODE_W-1:0] M_MON   = MODE_W'(NUM_LVL + 2);
   localparam logic [MODE_W-1:0] M_OCD   = MODE_W'(NUM_LVL + 3);
   localparam int NSLOT = 2;   // slot 0: monitor entry, slot 1: halted entry

   logic [MODE_W-1:0] mode_q, mode_d;
   logic [CLS_N-1:0]  mask_q, mask_d;
   logic              save_q;

   logic              in_mon, in_ocd, ret_take;
   logic [CLS_N-1:0]  req_vec, elig;
   logic              pick_vld, dbg_pick;
   logic [CLS_W-1:0]  pick_idx;
   logic [CLS_N-1:0]  fill;
   logic [MODE_W-1:0] ent_mode;
   logic [CLS_N-1:0]  ent_mask;
   dea_act_e          act;

   logic [NSLOT-1:0]  slot_ld;
   logic [MODE_W-1:0] slot_mode [NSLOT];
   logic [CLS_N-1:0]  slot_mask [NSLOT];
   logic [MODE_W-1:0] rest_mode;
   logic [CLS_N-1:0]  rest_mask;

   assign in_mon   = (mode_q == M_MON);
   assign in_ocd   = (mode_q == M_OCD);
   assign ret_take = ret_i & (in_mon | in_ocd);

   // halted mode blocks every class
   assign req_vec = {dbg_i, exc_i, irq_i};
   assign elig    = req_vec & ~mask_q & {CLS_N{~in_ocd}};

   dea_prio_pick #(.N(CLS_N)) u_pick (
      .req_i (elig),
      .vld_o (pick_vld),
      .idx_o (pick_idx)
   );

   dea_mask_fill #(.N(CLS_N)) u_fill (
      .idx_i  (pick_idx),
      .fill_o (fill)
   );

   assign dbg_pick = (pick_idx == DBG_IDX);

   always_comb begin
      if (dbg_pick) begin
         ent_mode = (in_mon || !mon_sel_i) ? M_OCD : M_MON;
         ent_mask = '1;
      end else begin
         ent_mode = MODE_W'(pick_idx) + MODE_W'(1);
         ent_mask = mask_q | fill;
      end
   end

   always_comb begin
      if (ret_take)       act = ACT_RET;
      else if (msk_we_i)  act = ACT_WRITE;
      else if (pick_vld)  act = ACT_ENTER;
      else                act = ACT_NONE;
   end

   // context slots, one per debug target
   assign slot_ld[0] = (act == ACT_ENTER) && dbg_pick && (ent_mode == M_MON);
   assign slot_ld[1] = (act == ACT_ENTER) && dbg_pick && (ent_mode == M_OCD);

   for (genvar s = 0; s < NSLOT; s++) begin : g_slot
      dea_ctx_slot #(.MODE_W(MODE_W), .MSK_W(CLS_N)) u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .ld_i   (slot_ld[s]),
         .mode_i (mode_q),
         .mask_i (mask_q),
         .mode_o (slot_mode[s]),
         .mask_o (slot_mask[s])
      );
   end

   assign rest_mode = in_ocd ? slot_mode[1] : slot_mode[0];
   assign rest_mask = in_ocd ? slot_mask[1] : slot_mask[0];

   always_comb begin
      mode_d = mode_q;
      mask_d = mask_q;
      unique case (act)
         ACT_RET: begin
            mode_d = rest_mode;
            mask_d = rest_mask;
         end
         ACT_WRITE: mask_d = msk_wdata_i;
         ACT_ENTER: begin
            mode_d = ent_mode;
            mask_d = ent_mask;
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         mask_q <= '0;
         save_q <= 1'b0;
      end else begin
         mode_q <= mode_d;
         mask_q <= mask_d;
         save_q <= (act == ACT_ENTER);
      end
   end

   // restored context is visible in the return cycle
   assign mode_o       = ret_take ? rest_mode : mode_q;
   assign mask_o       = ret_take ? rest_mask : mask_q;
   assign dbg_status_o = (mode_o == M_OCD);
   assign sr_dbg_o     = (mode_o == M_OCD) || (mode_o == M_MON);
   assign save_o       = save_q;

   // R1
   masked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ret_i && !msk_we_i && (({dbg_i, exc_i, irq_i} & ~mask_o) == '0))
      |=> (mode_q == $past(mode_q)));

   // R7
   ocd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_OCD && !ret_i) |=> (mode_q == M_OCD));

   // R5
   mon_to_ocd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == M_MON && dbg_i && !mask_q[DBG_BIT] && !ret_i && !msk_we_i)
      |=> (mode_q == M_OCD));

   // R4
   dbg_full_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (save_o && (mode_q == M_MON || mode_q == M_OCD)) |-> (&mask_q));

   // R10
   save_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      save_o |-> $past(!msk_we_i));

   // R6
   flag_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dbg_status_o |-> sr_dbg_o);

endmodule

// File: tb/dbg_entry_arb_bench.sv
`timescale 1ns/1ps
module dbg_entry_arb_bench;

   localparam int NL  = 4;
   localparam int CN  = NL + 2;
   localparam int MW  = 3;
   localparam int MON = NL + 2;
   localparam int OCD = NL + 3;
   localparam int ALL = (1 << CN) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] irq = '0;
   logic          exc = 1'b0, dbg = 1'b0, sel = 1'b0, ret = 1'b0, we = 1'b0;
   logic [CN-1:0] wd = '0;
   logic [MW-1:0] mode_o;
   logic [CN-1:0] mask_o;
   logic          dbg_status_o, sr_dbg_o, save_o;

   int n_chk = 0;
   int n_fail = 0;

   // behavioural reference state
   int m_mode, m_mask, m_save;
   int s_mode [2];
   int s_mask [2];

   always #2.5 clk = ~clk;

   dbg_entry_arb #(.NUM_LVL(NL)) u_dbg_entry_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .irq_i        (irq),
      .exc_i        (exc),
      .dbg_i        (dbg),
      .mon_sel_i    (sel),
      .ret_i        (ret),
      .msk_we_i     (we),
      .msk_wdata_i  (wd),
      .mode_o       (mode_o),
      .mask_o       (mask_o),
      .dbg_status_o (dbg_status_o),
      .sr_dbg_o     (sr_dbg_o),
      .save_o       (save_o)
   );

   task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      int em, ek, slot;
      em = m_mode;
      ek = m_mask;
      if (ret && (m_mode == MON || m_mode == OCD)) begin
         slot = (m_mode == OCD) ? 1 : 0;
         em = s_mode[slot];
         ek = s_mask[slot];
      end
      chk(int'(mode_o) == em, tag, "mode", int'(mode_o), em);
      chk(int'(mask_o) == ek, tag, "mask", int'(mask_o), ek);
      chk(int'(dbg_status_o) == int'(em == OCD), tag, "dbg_status", int'(dbg_status_o), int'(em == OCD));
      chk(int'(sr_dbg_o) == int'(em == OCD || em == MON), tag, "sr_dbg", int'(sr_dbg_o), int'(em == OCD || em == MON));
      chk(int'(save_o) == m_save, tag, "save", int'(save_o), m_save);
   endtask

   task automatic model_step();
      int req, pick, slot, tgt;
      req  = (int'(dbg) << (NL + 1)) | (int'(exc) << NL) | int'(irq);
      pick = -1;
      m_save = 0;
      if (ret && (m_mode == MON || m_mode == OCD)) begin
         slot = (m_mode == OCD) ? 1 : 0;
         m_mode = s_mode[slot];
         m_mask = s_mask[slot];
      end else if (we) begin
         m_mask = int'(wd);
      end else if (m_mode != OCD) begin
         for (int c = CN - 1; c >= 0; c--) begin
            if (pick < 0 && req[c] && !m_mask[c]) pick = c;
         end
         if (pick == NL + 1) begin
            tgt = (m_mode == MON || !sel) ? OCD : MON;
            slot = (tgt == OCD) ? 1 : 0;
            s_mode[slot] = m_mode;
            s_mask[slot] = m_mask;
            m_mode = tgt;
            m_mask = ALL;
            m_save = 1;
         end else if (pick >= 0) begin
            m_mode = pick + 1;
            m_mask = m_mask | ((2 << pick) - 1);
            m_save = 1;
         end
      end
   endtask

   task automatic cyc(input logic [NL-1:0] i_irq, input logic i_exc, input logic i_dbg,
                      input logic i_sel, input logic i_ret, input logic i_we,
                      input logic [CN-1:0] i_wd, input string tag);
      irq = i_irq; exc = i_exc; dbg = i_dbg; sel = i_sel;
      ret = i_ret; we = i_we; wd = i_wd;
      #1;
      compare(tag);
      @(posedge clk);
      model_step();
      #1;
   endtask

   task automatic idle(input string tag);
      cyc('0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, tag);
   endtask

   initial begin
      #(5.0 * 200000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin
      m_mode = 0; m_mask = 0; m_save = 0;
      s_mode[0] = 0; s_mode[1] = 0; s_mask[0] = 0; s_mask[1] = 0;
      repeat (3) @(posedge clk);
      #1;
      chk(mode_o == '0, "R11", "mode", int'(mode_o), 0);
      chk(mask_o == '0, "R11", "mask", int'(mask_o), 0);
      chk({dbg_status_o, sr_dbg_o, save_o} == 3'b000, "R11", "flags",
          int'({dbg_status_o, sr_dbg_o, save_o}), 0);
      rst_n = 1'b1;
      @(posedge clk);
      #1;

      // climb through the classes
      cyc(4'b0010, 0, 0, 1, 0, 0, '0, "R2");
      idle("R10");
      cyc(4'b0001, 0, 0, 1, 0, 0, '0, "R1");
      idle("R1");
      cyc(4'b1000, 0, 0, 1, 0, 0, '0, "R3");
      idle("R3");
      cyc(4'b0000, 1, 0, 1, 0, 0, '0, "R2");
      idle("R3");
      // monitor entry and its debug mask
      cyc('0, 0, 1, 1, 0, 0, '0, "R4");
      idle("R6");
      cyc('0, 0, 1, 1, 0, 0, '0, "R4");
      idle("R4");
      cyc('0, 0, 0, 1, 0, 1, 6'b011111, "R8");
      idle("R8");
      // nested halted entry from monitor
      cyc('0, 0, 1, 1, 0, 0, '0, "R5");
      idle("R6");
      cyc('0, 0, 0, 1, 0, 1, 6'b000000, "R8");
      cyc(4'b1111, 1, 1, 0, 0, 0, '0, "R7");
      cyc(4'b1111, 1, 1, 1, 0, 0, '0, "R7");
      // unwind
      cyc('0, 0, 0, 1, 1, 0, '0, "R9");
      idle("R9");
      cyc('0, 0, 0, 1, 1, 0, '0, "R9");
      idle("R9");
      cyc('0, 0, 0, 1, 1, 0, '0, "R9");
      idle("R9");
      // simultaneous requests and write precedence
      cyc('0, 0, 0, 1, 0, 1, 6'b000000, "R8");
      cyc(4'b1001, 0, 0, 1, 0, 0, '0, "R2");
      idle("R2");
      cyc('0, 0, 0, 1, 0, 1, 6'b000000, "R8");
      cyc(4'b0100, 0, 0, 1, 0, 1, 6'b000000, "R8");
      idle("R8");
      cyc(4'b0110, 1, 1, 0, 0, 0, '0, "R2");
      idle("R4");
      cyc('0, 0, 0, 1, 1, 1, 6'b101010, "R9");
      idle("R9");

      // random phase
      for (int n = 0; n < 4000; n++) begin
         logic [31:0] r;
         r = $urandom;
         cyc(r[3:0] & r[7:4], r[8] & r[9], r[10] & r[11], r[12],
             (r[15:13] == 3'b000), (r[18:16] == 3'b000), r[24:19], "R2");
      end

      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule